// File: doc/BRIEF.md
# Pulse-Swallow Dual-Modulus Frequency Divider

This block divides a fast input clock by a programmable integer N and emits one single-cycle pulse per N input cycles. Inside, a prescaler counts either P+1 or P input cycles. A swallow counter and a main counter count the prescaler's terminal events. The main counter is loaded with b and sets how many prescaler periods make up one output period. The swallow counter is loaded with a and sets how many of those periods use the longer P+1 length. The output period is therefore N = P·b + a. Any integer N can be reached, provided b = floor(N/P), a = N mod P, and b is at least a.

The settings a and b are taken from the inputs only at the moment a new output period begins. Changes made while a period is running therefore never disturb that period. An input pair that cannot be divided (b smaller than a, or b equal to zero) raises an error flag. A period that starts while such a pair is present reuses the last legal settings. The prescaler modulus P is a build-time parameter.

Top module: `pulse_swallow_div`

## Requirements
- R1: For a legal setting (b ≥ 1 and b ≥ a), consecutive rising pulses on `div_pulse` are exactly P·b + a input cycles apart.
- R2: `mod_hi` = 1 selects the P+1 prescaler length and 0 selects P. In each period, counted from the cycle carrying the pulse, `mod_hi` is high for the first a·(P+1) cycles and low for the remaining (b−a)·P cycles.
- R3: With a = 0, `mod_hi` stays low for the whole period and the period is P·b, a multiple of P.
- R4: With a = b, `mod_hi` stays high for the whole period and the period is a·(P+1).
- R5: `div_pulse` is high for exactly one input cycle per period. That cycle is the first cycle of the new period.
- R6: `a_in` and `b_in` are sampled only at the clock edge that starts a new period. Values present at any other edge have no effect on any period length or on `mod_hi`.
- R7: `cfg_err` is high in the cycle after an edge at which `b_in < a_in` or `b_in = 0`, and low in the cycle after an edge with a legal pair.
- R8: When a period starts while an illegal pair is applied, that period uses the most recent legal settings.
- R9: A synchronous reset drives `div_pulse`, `cfg_err` and `mod_hi` low (default a = 0). The first period after reset uses the reset settings: N = P·1 + 0.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | High-rate input clock being divided |
| rst | input | 1 | Synchronous reset, active high |
| a_in | input | A_W | Swallow count a (number of P+1 prescaler periods) |
| b_in | input | B_W | Main count b (total prescaler periods per output period) |
| div_pulse | output | 1 | One-cycle pulse marking the start of each output period |
| mod_hi | output | 1 | Modulus control: 1 = prescaler divides by P+1, 0 = by P |
| cfg_err | output | 1 | Registered flag: applied pair is illegal |

## Verification
The case that is hardest to reach from the ports is a settings change that happens inside a running period and is gone again before the period ends. This must leave both the period length and the `mod_hi` profile untouched. The stimulus reacts to each observed pulse: it applies a junk pair a few cycles into the period and restores the previous pair well before the reload edge. A second awkward case is an illegal pair that is still present at a reload edge. The stimulus keeps such a pair applied across whole periods, so the held legal settings must govern them.

// File: rtl/psd_pkg.sv
`timescale 1ns/1ps
package psd_pkg;

    typedef enum logic {
        MODE_LO = 1'b0,
        MODE_HI = 1'b1
    } psd_mode_e;

endpackage

// File: rtl/psd_prescaler.sv
`timescale 1ns/1ps
module psd_prescaler
    import psd_pkg::*;
#(
    parameter int PRE_MOD = 4,
    parameter bit RST_HI  = 1'b0
) (
    input  logic      clk,
    input  logic      rst,
    input  psd_mode_e next_mode,
    output logic      tick
);

    localparam int CW = $clog2(PRE_MOD + 1);
    localparam logic [CW-1:0] TOP_HI = CW'(PRE_MOD);
    localparam logic [CW-1:0] TOP_LO = CW'(PRE_MOD - 1);
    localparam logic [CW-1:0] TOP_RST = RST_HI ? TOP_HI : TOP_LO;

    typedef struct packed {
        logic [CW-1:0] cnt;
    } pre_state_t;

    pre_state_t s_d, s_q;

    always_comb begin
        s_d  = s_q;
        tick = (s_q.cnt == '0);
        if (tick) begin
            s_d.cnt = (next_mode == MODE_HI) ? TOP_HI : TOP_LO;
        end else begin
            s_d.cnt = s_q.cnt - CW'(1);
        end
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            s_q.cnt <= TOP_RST;
        end else begin
            s_q <= s_d;
        end
    end

endmodule

// File: rtl/psd_counters.sv
`timescale 1ns/1ps
module psd_counters
    import psd_pkg::*;
#(
    parameter int A_W   = 4,
    parameter int B_W   = 6,
    parameter int RST_A = 0,
    parameter int RST_B = 1
) (
    input  logic           clk,
    input  logic           rst,
    input  logic           tick,
    input  logic [A_W-1:0] load_a,
    input  logic [B_W-1:0] load_b,
    output psd_mode_e      next_mode,
    output psd_mode_e      cur_mode,
    output logic           reload,
    output logic           pulse
);

    typedef struct packed {
        logic [A_W-1:0] a_cnt;
        logic [B_W-1:0] b_cnt;
        logic           pulse;
    } ctr_state_t;

    ctr_state_t s_d, s_q;

    always_comb begin
        s_d       = s_q;
        reload    = tick && (s_q.b_cnt == B_W'(1));
        s_d.pulse = reload;
        if (reload) begin
            s_d.a_cnt = load_a;
            s_d.b_cnt = load_b;
        end else if (tick) begin
            s_d.b_cnt = s_q.b_cnt - B_W'(1);
            if (s_q.a_cnt != '0) begin
                s_d.a_cnt = s_q.a_cnt - A_W'(1);
            end
        end
        next_mode = (s_d.a_cnt != '0) ? MODE_HI : MODE_LO;
        cur_mode  = (s_q.a_cnt != '0) ? MODE_HI : MODE_LO;
        pulse     = s_q.pulse;
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            s_q.a_cnt <= A_W'(RST_A);
            s_q.b_cnt <= B_W'(RST_B);
            s_q.pulse <= 1'b0;
        end else begin
            s_q <= s_d;
        end
    end

endmodule

// File: rtl/psd_cfg_guard.sv
`timescale 1ns/1ps
module psd_cfg_guard #(
    parameter int A_W   = 4,
    parameter int B_W   = 6,
    parameter int RST_A = 0,
    parameter int RST_B = 1
) (
    input  logic           clk,
    input  logic           rst,
    input  logic [A_W-1:0] a_in,
    input  logic [B_W-1:0] b_in,
    input  logic           reload,
    output logic [A_W-1:0] load_a,
    output logic [B_W-1:0] load_b,
    output logic [A_W-1:0] held_a,
    output logic [B_W-1:0] held_b,
    output logic           err
);

    localparam int CW = (A_W > B_W) ? A_W : B_W;

    typedef struct packed {
        logic [A_W-1:0] a;
        logic [B_W-1:0] b;
        logic           err;
    } grd_state_t;

    grd_state_t s_d, s_q;
    logic [CW-1:0] a_ext, b_ext;
    logic          bad;

    always_comb begin
        a_ext  = CW'(a_in);
        b_ext  = CW'(b_in);
        bad    = (b_ext < a_ext) || (b_in == '0);
        load_a = bad ? s_q.a : a_in;
        load_b = bad ? s_q.b : b_in;
        s_d     = s_q;
        s_d.err = bad;
        if (reload && !bad) begin
            s_d.a = a_in;
            s_d.b = b_in;
        end
        held_a = s_q.a;
        held_b = s_q.b;
        err    = s_q.err;
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            s_q.a   <= A_W'(RST_A);
            s_q.b   <= B_W'(RST_B);
            s_q.err <= 1'b0;
        end else begin
            s_q <= s_d;
        end
    end

endmodule

// File: rtl/pulse_swallow_div.sv
`timescale 1ns/1ps
module pulse_swallow_div
    import psd_pkg::*;
#(
    parameter int PRE_MOD = 4,
    parameter int A_W     = 4,
    parameter int B_W     = 6,
    parameter int RST_A   = 0,
    parameter int RST_B   = 1
) (
    input  logic           clk,
    input  logic           rst,
    input  logic [A_W-1:0] a_in,
    input  logic [B_W-1:0] b_in,
    output logic           div_pulse,
    output logic           mod_hi,
    output logic           cfg_err
);

    localparam bit RST_HI = (RST_A != 0);

    psd_mode_e      nxt_mode;
    psd_mode_e      cur_mode;
    logic           pre_tick;
    logic           ctr_reload;
    logic           ctr_pulse;
    logic [A_W-1:0] ld_a;
    logic [B_W-1:0] ld_b;
    logic [A_W-1:0] grd_held_a;
    logic [B_W-1:0] grd_held_b;
    logic           grd_err;

    psd_prescaler #(
        .PRE_MOD (PRE_MOD),
        .RST_HI  (RST_HI)
    ) u_pre (
        .clk       (clk),
        .rst       (rst),
        .next_mode (nxt_mode),
        .tick      (pre_tick)
    );

    psd_counters #(
        .A_W   (A_W),
        .B_W   (B_W),
        .RST_A (RST_A),
        .RST_B (RST_B)
    ) u_ctr (
        .clk       (clk),
        .rst       (rst),
        .tick      (pre_tick),
        .load_a    (ld_a),
        .load_b    (ld_b),
        .next_mode (nxt_mode),
        .cur_mode  (cur_mode),
        .reload    (ctr_reload),
        .pulse     (ctr_pulse)
    );

    psd_cfg_guard #(
        .A_W   (A_W),
        .B_W   (B_W),
        .RST_A (RST_A),
        .RST_B (RST_B)
    ) u_grd (
        .clk    (clk),
        .rst    (rst),
        .a_in   (a_in),
        .b_in   (b_in),
        .reload (ctr_reload),
        .load_a (ld_a),
        .load_b (ld_b),
        .held_a (grd_held_a),
        .held_b (grd_held_b),
        .err    (grd_err)
    );

    assign div_pulse = ctr_pulse;
    assign mod_hi    = (cur_mode == MODE_HI);
    assign cfg_err   = grd_err;

endmodule

// File: rtl/psd_checker.sv
`timescale 1ns/1ps
module psd_checker #(
    parameter int A_W = 4,
    parameter int B_W = 6
) (
    input logic           clk,
    input logic           rst,
    input logic [A_W-1:0] a_in,
    input logic [B_W-1:0] b_in,
    input logic           div_pulse,
    input logic           mod_hi,
    input logic           cfg_err,
    input logic           reload,
    input logic [A_W-1:0] held_a,
    input logic [B_W-1:0] held_b
);

    localparam int CW = (A_W > B_W) ? A_W : B_W;

    logic in_illegal;
    logic held_ok;

    always_comb begin
        in_illegal = (b_in == '0) || (CW'(b_in) < CW'(a_in));
        held_ok    = (held_b != '0) && (CW'(held_b) >= CW'(held_a));
    end

    AST_PULSE_SINGLE: assert property (@(posedge clk) disable iff (rst)
        div_pulse |=> !div_pulse);                                   // R5

    AST_MODE_RISE_AT_START: assert property (@(posedge clk) disable iff (rst)
        $rose(mod_hi) |-> div_pulse);                                // R2

    AST_ERR_ON_ILLEGAL: assert property (@(posedge clk) disable iff (rst)
        in_illegal |=> cfg_err);                                     // R7

    AST_ERR_CLEAR_ON_LEGAL: assert property (@(posedge clk) disable iff (rst)
        !in_illegal |=> !cfg_err);                                   // R7

    AST_HELD_ONLY_AT_RELOAD: assert property (@(posedge clk) disable iff (rst)
        !reload |=> ($stable(held_a) && $stable(held_b)));           // R6

    AST_HELD_LEGAL: assert property (@(posedge clk) disable iff (rst)
        held_ok);                                                    // R8

endmodule

bind pulse_swallow_div psd_checker #(
    .A_W (A_W),
    .B_W (B_W)
) u_chk (
    .clk       (clk),
    .rst       (rst),
    .a_in      (a_in),
    .b_in      (b_in),
    .div_pulse (div_pulse),
    .mod_hi    (mod_hi),
    .cfg_err   (cfg_err),
    .reload    (ctr_reload),
    .held_a    (grd_held_a),
    .held_b    (grd_held_b)
);

// File: tb/pulse_swallow_div_tb.sv
`timescale 1ns/1ps
module pulse_swallow_div_tb;

    localparam int P   = 4;
    localparam int A_W = 4;
    localparam int B_W = 6;

    typedef struct {
        int    n;
        int    hi;
        string tag;
    } exp_t;

    logic           clk = 1'b0;
    logic           rst = 1'b1;
    logic [A_W-1:0] a_in = '0;
    logic [B_W-1:0] b_in = B_W'(1);
    logic           div_pulse, mod_hi, cfg_err;

    exp_t exp_q[$];
    int   n_checks = 0;
    int   n_fails  = 0;
    int   cur_a = 0, cur_b = 1, held_a = 0, held_b = 1;

    always #4 clk = ~clk;

    pulse_swallow_div #(
        .PRE_MOD (P),
        .A_W     (A_W),
        .B_W     (B_W),
        .RST_A   (0),
        .RST_B   (1)
    ) u_dut (
        .clk       (clk),
        .rst       (rst),
        .a_in      (a_in),
        .b_in      (b_in),
        .div_pulse (div_pulse),
        .mod_hi    (mod_hi),
        .cfg_err   (cfg_err)
    );

    function automatic bit legal(int a, int b);
        return (b != 0) && (b >= a);
    endfunction

    task automatic check(bit ok, string req, int act, int expv);
        n_checks++;
        if (!ok) begin
            n_fails++;
            $display("FAIL %s: actual %0d expected %0d", req, act, expv);
        end
    endtask

    task automatic push_held(string tag);
        exp_t e;
        e.n   = P * held_b + held_a;
        e.hi  = held_a * (P + 1);
        e.tag = tag;
        exp_q.push_back(e);
    endtask

    task automatic wait_pulse_push(string tag);
        do @(negedge clk); while (!div_pulse);
        if (legal(cur_a, cur_b)) begin
            held_a = cur_a;
            held_b = cur_b;
        end
        push_held(tag);
    endtask

    task automatic set_in(int a, int b);
        cur_a = a;
        cur_b = b;
        a_in  = A_W'(a);
        b_in  = B_W'(b);
    endtask

    // apply a pair right after a pulse, check the error flag, follow n periods
    task automatic drive(int a, int b, int n, string tag);
        set_in(a, b);
        @(negedge clk);
        check(cfg_err == !legal(a, b), "R7 cfg_err", int'(cfg_err), int'(!legal(a, b)));
        repeat (n) wait_pulse_push(tag);
    endtask

    // junk pair applied mid-period and removed before the reload (R6)
    task automatic glitch_period();
        int sa, sb;
        sa = cur_a;
        sb = cur_b;
        repeat (2) @(negedge clk);
        a_in = A_W'(9);
        b_in = B_W'(2);
        @(negedge clk);
        a_in = A_W'(sa);
        b_in = B_W'(sb);
        wait_pulse_push("R6 glitch");
    endtask

    // monitor: measures every period and compares against the queue
    initial begin
        bit running = 0;
        bit prev_pulse = 0;
        int cnt = 0, hi = 0;
        forever begin
            @(negedge clk);
            #1;
            if (rst) begin
                running = 0;
            end else if (!running) begin
                running = 1;
                cnt = 1;
                hi = int'(mod_hi);
                prev_pulse = div_pulse;
            end else begin
                if (prev_pulse) begin
                    check(!div_pulse, "R5 pulse width", int'(div_pulse), 0);
                end
                if (div_pulse) begin
                    if (exp_q.size() == 0) begin
                        check(0, "R1 queue empty", cnt, -1);
                    end else begin
                        exp_t e;
                        e = exp_q.pop_front();
                        check(cnt == e.n, {"R1 period ", e.tag}, cnt, e.n);
                        check(hi == e.hi, {"R2 mod_hi cycles ", e.tag}, hi, e.hi);
                    end
                    cnt = 1;
                    hi = int'(mod_hi);
                end else begin
                    cnt++;
                    hi += int'(mod_hi);
                end
                prev_pulse = div_pulse;
            end
        end
    end

    initial begin
        repeat (200000) @(posedge clk);
        n_fails++;
        $display("FAIL watchdog: actual %0d expected %0d", 1, 0);
        $display("== %0d vectors applied, %0d miscompares ==", n_checks, n_fails);
        $finish;
    end

    initial begin
        repeat (3) @(negedge clk);
        check(div_pulse == 1'b0, "R9 reset pulse", int'(div_pulse), 0);
        check(cfg_err == 1'b0, "R9 reset err", int'(cfg_err), 0);
        check(mod_hi == 1'b0, "R9 reset mod", int'(mod_hi), 0);
        rst = 1'b0;
        push_held("R9 reset period");
        drive(0, 1, 2, "R9 default");
        drive(3, 5, 3, "R1 mixed");
        drive(0, 6, 2, "R3 a zero");
        drive(7, 7, 2, "R4 a equals b");
        drive(2, 1, 2, "R8 b below a");
        drive(1, 0, 1, "R8 b zero");
        drive(15, 63, 2, "R1 max");
        drive(1, 1, 2, "R4 smallest");
        drive(2, 3, 1, "R6 base");
        glitch_period();
        glitch_period();
        drive(0, 1, 3, "R3 minimum");
        $display("== %0d vectors applied, %0d miscompares ==", n_checks, n_fails);
        $finish;
    end

endmodule